// File: doc/BRIEF.md
# Sample Clock and Channel Sequencer

This block produces the conversion strobe for a four-channel simultaneous-sampling acquisition front end, and tags each strobe with the channel it belongs to. Software controls it through one 16-bit configuration word. The word picks a master clock period and a power-of-two stretch of that period, chooses which channels make up a scan, and carries the pair enable, pair coupling and power-down controls for the analog side.

At every sample-period boundary the block takes over the most recently written configuration. It then issues one strobe per active channel on consecutive clock cycles, in ascending channel order, and flags the first strobe of each scan. A settling indicator tells downstream logic when the sample clock has run unchanged long enough for converted data to be trusted. A one-cycle pulse reports each write that alters the clock setting.

The four master clocks are modelled as fixed divisions of the block clock, set by parameters.

Top module: `acq_sample_sequencer`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `smp_strobe`, `scan_first`, `smp_grounded`, `data_ok` and `clk_changed` are 0, and `pair_enable`, `ac_couple` and `analog_pd` are 0.
- R2: Bits [2:0] of the configuration select the scan set. Code 1cc gives the single channel cc. Code 010 gives channels 0 and 1, code 011 gives channels 2 and 3, and code 001 gives channels 0, 1, 2 and 3. Each scan strobes its channels once each, in ascending order, with `smp_chan` carrying the channel number.
- R3: The sample period in block clock cycles is MDIVk shifted left by e. Here k is bits [4:3], selecting parameter MDIV0 to MDIV3, and e is bits [6:5]. The strobes of a scan fall on consecutive cycles, starting in the cycle after a boundary edge.
- R4: `scan_first` is high together with the strobe of the lowest channel in each scan, and low at all other times.
- R5: A configuration write is applied at the next sample-period boundary and not before. The outputs `pair_enable` (bits 8:7 → [1:0]), `ac_couple` (bits 10:9 → [1:0]) and `analog_pd` (bit 11) all follow the applied value.
- R6: `smp_grounded` is high with a strobe whose channel pair is disabled in the applied configuration. Bit 7 covers channels 0 and 1, and bit 8 covers channels 2 and 3.
- R7: `data_ok` rises once SETTLE_PERIODS (default 72) boundaries have passed in a row with the clock field (bits 6:3) unchanged from the previously applied value. A boundary with a changed clock field, a reset, or digital power-down clears the count.
- R8: `clk_changed` pulses for one cycle after each write whose bits [6:3] differ from the last written value. Writes that leave those bits unchanged give no pulse.
- R9: While written bit 12 (digital power-down) is set, the sequencer is held reset from the next cycle on. That means no strobes and `data_ok` low. After the bit is cleared, the first boundary occurs on the next edge.
- R10: Channel code 000 produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| smp_strobe | output | 1 | Conversion strobe, one per channel per scan |
| smp_chan | output | 2 | Channel of the current strobe |
| scan_first | output | 1 | First strobe of a scan |
| smp_grounded | output | 1 | Current strobe's channel pair is disabled |
| data_ok | output | 1 | Sample clock has settled |
| clk_changed | output | 1 | Pulse after a write that altered the clock field |
| pair_enable | output | 2 | Applied pair enables |
| ac_couple | output | 2 | Applied pair coupling selects |
| analog_pd | output | 1 | Applied analog power-down |

## Verification
The hardest state to reach from the ports is `data_ok` rising. It needs dozens of back-to-back sample periods with no change in the clock field, and the random write traffic keeps clearing the count. The stimulus therefore includes a directed stretch at the longest period. Its writes change only the scan code and the enables, so the bench can check that the count survives them. It also covers a write that lands on a boundary edge and a power-down applied in the middle of a scan.

// File: rtl/acq_sample_sequencer.sv
module acq_sample_sequencer #(
  parameter int MDIV0 = 5,
  parameter int MDIV1 = 6,
  parameter int MDIV2 = 7,
  parameter int MDIV3 = 8,
  parameter int SETTLE_PERIODS = 72
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic        smp_strobe,
  output logic [1:0]  smp_chan,
  output logic        scan_first,
  output logic        smp_grounded,
  output logic        data_ok,
  output logic        clk_changed,
  output logic [1:0]  pair_enable,
  output logic [1:0]  ac_couple,
  output logic        analog_pd
);
  localparam int MAXDIV = (MDIV0 > MDIV1 ? MDIV0 : MDIV1) > (MDIV2 > MDIV3 ? MDIV2 : MDIV3)
                        ? (MDIV0 > MDIV1 ? MDIV0 : MDIV1) : (MDIV2 > MDIV3 ? MDIV2 : MDIV3);
  localparam int CNT_W = $clog2(MAXDIV * 8);
  localparam int SET_W = $clog2(SETTLE_PERIODS + 1);

  logic [15:0]      pend, act;
  logic [CNT_W-1:0] cnt, per_m1;
  logic [2:0]       rem, n_cnt;
  logic [1:0]       nxt, n_first;
  logic [SET_W-1:0] settle;
  logic             strobe_q, first_q, chg_q;
  logic [1:0]       chan_q;

  wire dpd      = pend[12];
  wire boundary = (cnt == '0);

  always_comb begin
    int base;
    case (pend[4:3])
      2'd0:    base = MDIV0;
      2'd1:    base = MDIV1;
      2'd2:    base = MDIV2;
      default: base = MDIV3;
    endcase
    per_m1 = CNT_W'((base << pend[6:5]) - 1);
  end

  always_comb begin
    n_cnt   = 3'd0;
    n_first = 2'd0;
    casez (pend[2:0])
      3'b1??: begin n_cnt = 3'd1; n_first = pend[1:0]; end
      3'b010: begin n_cnt = 3'd2; n_first = 2'd0; end
      3'b011: begin n_cnt = 3'd2; n_first = 2'd2; end
      3'b001: begin n_cnt = 3'd4; n_first = 2'd0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; act <= '0; cnt <= '0; rem <= '0; nxt <= '0;
      strobe_q <= 1'b0; first_q <= 1'b0; chan_q <= '0;
      settle <= '0; chg_q <= 1'b0;
    end else begin
      chg_q <= cfg_we && (cfg_wdata[6:3] != pend[6:3]);
      if (cfg_we) pend <= cfg_wdata;
      if (dpd) begin
        act <= pend; cnt <= '0; rem <= '0; nxt <= '0;
        strobe_q <= 1'b0; first_q <= 1'b0; chan_q <= '0; settle <= '0;
      end else if (boundary) begin
        act      <= pend;
        cnt      <= per_m1;
        strobe_q <= (n_cnt != 3'd0);
        first_q  <= (n_cnt != 3'd0);
        chan_q   <= n_first;
        rem      <= (n_cnt == 3'd0) ? 3'd0 : n_cnt - 3'd1;
        nxt      <= n_first + 2'd1;
        if (pend[6:3] != act[6:3])        settle <= '0;
        else if (settle != SET_W'(SETTLE_PERIODS)) settle <= settle + 1'b1;
      end else begin
        cnt     <= cnt - 1'b1;
        first_q <= 1'b0;
        if (rem != 3'd0) begin
          strobe_q <= 1'b1;
          chan_q   <= nxt;
          nxt      <= nxt + 2'd1;
          rem      <= rem - 3'd1;
        end else begin
          strobe_q <= 1'b0;
        end
      end
    end
  end

  assign smp_strobe   = strobe_q;
  assign smp_chan     = chan_q;
  assign scan_first   = first_q;
  assign smp_grounded = strobe_q & ~(chan_q[1] ? act[8] : act[7]);
  assign data_ok      = (settle == SET_W'(SETTLE_PERIODS));
  assign clk_changed  = chg_q;
  assign pair_enable  = act[8:7];
  assign ac_couple    = act[10:9];
  assign analog_pd    = act[11];
endmodule

// File: rtl/acq_sample_sequencer_chk.sv
module acq_sample_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       dpd,
  input logic [2:0] code,
  input logic       smp_strobe,
  input logic [1:0] smp_chan,
  input logic       scan_first,
  input logic       smp_grounded,
  input logic       clk_changed
);
  assert_first_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_first |-> smp_strobe);

  assert_grounded_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_grounded |-> smp_strobe);

  assert_pair01_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_strobe && code == 3'b010) |-> !smp_chan[1]);

  assert_pair23_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_strobe && code == 3'b011) |-> smp_chan[1]);

  assert_code0_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |-> (code != 3'b000));

  assert_dpd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dpd |=> !smp_strobe);

  assert_chg_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_changed |-> $past(cfg_we));
endmodule

bind acq_sample_sequencer acq_sample_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .dpd(pend[12]), .code(act[2:0]),
  .smp_strobe(smp_strobe), .smp_chan(smp_chan), .scan_first(scan_first),
  .smp_grounded(smp_grounded), .clk_changed(clk_changed)
);

// File: tb/acq_sample_sequencer_bench.sv
`timescale 1ns/1ps
module acq_sample_sequencer_bench;
  localparam int D0 = 5, D1 = 6, D2 = 7, D3 = 8, SETTLE = 72;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [15:0] cfg_wdata = '0;
  logic smp_strobe, scan_first, smp_grounded, data_ok, clk_changed, analog_pd;
  logic [1:0] smp_chan, pair_enable, ac_couple;

  always #5 clk = ~clk;

  acq_sample_sequencer #(.MDIV0(D0), .MDIV1(D1), .MDIV2(D2), .MDIV3(D3),
                         .SETTLE_PERIODS(SETTLE)) u_acq_sample_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .smp_strobe(smp_strobe), .smp_chan(smp_chan), .scan_first(scan_first),
    .smp_grounded(smp_grounded), .data_ok(data_ok), .clk_changed(clk_changed),
    .pair_enable(pair_enable), .ac_couple(ac_couple), .analog_pd(analog_pd));

  int compared = 0, mismatched = 0;
  string str_tag = "R3";
  bit done = 0;

  // expected behaviour, derived from the requirements
  function automatic int period_of(input logic [15:0] c);
    int b;
    case (c[4:3]) 0: b = D0; 1: b = D1; 2: b = D2; default: b = D3; endcase
    return b << c[6:5];
  endfunction

  function automatic int scan_len(input logic [2:0] code);
    if (code[2]) return 1;
    if (code == 3'b010 || code == 3'b011) return 2;
    if (code == 3'b001) return 4;
    return 0;
  endfunction

  function automatic int scan_low(input logic [2:0] code);
    if (code[2]) return code[1:0];
    if (code == 3'b011) return 2;
    return 0;
  endfunction

  logic [15:0] m_pend, m_act;
  int m_left, m_pos, m_len, m_low, m_settle;
  bit e_strobe, e_first, e_chg;
  int e_chan;

  always @(posedge clk) begin
    logic [15:0] op;
    op = m_pend;
    if (!rst_n) begin
      m_pend = '0; m_act = '0; m_left = 0; m_pos = 0; m_len = 0; m_low = 0;
      m_settle = 0; e_strobe = 0; e_first = 0; e_chg = 0; e_chan = 0;
    end else begin
      e_chg = cfg_we && (cfg_wdata[6:3] != op[6:3]);
      if (cfg_we) m_pend = cfg_wdata;
      if (op[12]) begin
        m_act = op; m_left = 0; m_pos = 0; m_len = 0; m_settle = 0;
        e_strobe = 0; e_first = 0;
      end else if (m_left == 0) begin
        if (op[6:3] != m_act[6:3]) m_settle = 0;
        else if (m_settle < SETTLE) m_settle++;
        m_act = op;
        m_left = period_of(op) - 1;
        m_len = scan_len(op[2:0]); m_low = scan_low(op[2:0]); m_pos = 0;
        e_strobe = (m_len > 0); e_first = e_strobe;
        if (e_strobe) e_chan = m_low;
      end else begin
        m_left--;
        m_pos++;
        e_first = 0;
        e_strobe = (m_pos < m_len);
        if (e_strobe) e_chan = m_low + m_pos;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit eg;
    eg = e_strobe && !((e_chan >= 2) ? m_act[8] : m_act[7]);
    chk(smp_strobe == e_strobe, str_tag, smp_strobe, e_strobe);
    if (e_strobe) chk(smp_chan == 2'(e_chan), "R2", smp_chan, e_chan);
    chk(scan_first == e_first, "R4", scan_first, e_first);
    chk(smp_grounded == eg, "R6", smp_grounded, eg);
    chk(data_ok == (m_settle == SETTLE), "R7", data_ok, m_settle == SETTLE);
    chk(clk_changed == e_chg, "R8", clk_changed, e_chg);
    chk({pair_enable, ac_couple, analog_pd} == {m_act[8:7], m_act[10:9], m_act[11]},
        "R5", {pair_enable, ac_couple, analog_pd}, {m_act[8:7], m_act[10:9], m_act[11]});
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      cfg_we = 0;
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    compare_all();
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    compare_all();
    cfg_we = 0;
  endtask

  function automatic logic [15:0] rand_cfg();
    logic [15:0] v;
    logic [2:0] codes [8] = '{3'b100, 3'b101, 3'b110, 3'b111, 3'b010, 3'b011, 3'b001, 3'b000};
    v = 16'($urandom) & 16'h0FF8;
    v[2:0] = codes[$urandom_range(7, 0)];
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({smp_strobe, scan_first, smp_grounded, data_ok, clk_changed} == 5'b0, "R1",
        {smp_strobe, scan_first, smp_grounded, data_ok, clk_changed}, 0);
    chk({pair_enable, ac_couple, analog_pd} == 5'b0, "R1",
        {pair_enable, ac_couple, analog_pd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(smp_strobe == 0 && data_ok == 0 && clk_changed == 0, "R1", smp_strobe, 0);

    // all four channels, every pair enabled, fastest clock
    write_cfg(16'h0181);
    step(40);
    // single channel 3, pair 2/3 grounded (R6)
    write_cfg(16'h0087);
    step(30);
    // pair 2/3, slowest period
    write_cfg(16'h017B);
    step(150);

    // R10: reserved code
    str_tag = "R10";
    write_cfg(16'h0180);
    step(60);
    str_tag = "R3";

    // R8: same clock field rewritten -> no pulse; changed -> pulse
    write_cfg(16'h0182);
    write_cfg(16'h0192);
    step(20);

    // R7: long settle at the longest period, only non-clock bits change
    write_cfg(16'h0179);
    step(200);
    for (int k = 0; k < 80; k++) begin
      logic [15:0] v;
      v = rand_cfg();
      v[6:3] = 4'hF;
      v[12] = 1'b0;
      write_cfg(v);
      step(60);
    end

    // R9: digital power-down in the middle of a scan
    write_cfg(16'h0009);
    step(3);
    str_tag = "R9";
    write_cfg(16'h1009);
    step(25);
    write_cfg(16'h0009);
    str_tag = "R3";
    step(40);

    // random mix, including writes landing on boundary edges (R5)
    for (int k = 0; k < 150; k++) begin
      write_cfg(rand_cfg());
      step($urandom_range(40, 0));
    end
    step(100);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule